// File: doc/BRIEF.md
# Master Transfer Byte Buffer

A four-entry byte buffer that sits between a host register port and a serial bus master engine. The host pushes bytes to the buffer before a transmit and pops them after a receive. The oldest byte always sits at the head and can be read without a pop. After a receive, the engine can replace the first N entries and set the occupancy in a single cycle.

Two status flags report the buffer state: `has_data` and `full`. They are not decoded from the fill level. Each flag is a register that changes only on specific occupancy transitions, on a flush or on an engine load. An engine load can set a flag but never clears one, so a flag can stay set after the level has dropped.

The host sees the value `{DW{1'b1}}` (0xFF) when it reads an empty buffer. A push to a full buffer is dropped without notice.

Top module: `byte_stage_buf`

## Requirements
- R1: After reset, `fill` is 0, `has_data` and `full` are 0, and `head_data` reads 0xFF.
- R2: When `push` is accepted and `fill` < DEPTH, `push_data` is stored behind the bytes already held and `fill` rises by one.
- R3: A `push` while `fill` == DEPTH has no effect on `fill`, on the flags or on the stored bytes.
- R4: `head_data` shows the oldest stored byte. An accepted `pop` with `fill` > 0 removes that byte, moves the rest up by one and lowers `fill` by one, so bytes leave in push order.
- R5: While `fill` is 0, `head_data` is 0xFF, and a `pop` changes nothing.
- R6: A push that raises `fill` from 0 to 1 sets `has_data`. A push that raises `fill` to DEPTH sets `full`.
- R7: A pop taken at `fill` == DEPTH clears `full`. A pop taken at `fill` == 1 clears `has_data`. No other push or pop changes either flag.
- R8: `flush` sets `fill` to 0, zeroes every entry and clears both flags.
- R9: An engine load with count N (0..DEPTH) sets `fill` to N and stores byte i of `eng_bytes` (bits i*DW upward) into entry i for every i < N. It sets `has_data` if N ≥ 1 and sets `full` if N == DEPTH. It never clears either flag.
- R10: When requests arrive in the same cycle, only the highest-priority one is accepted, in the order `flush`, engine load, `pop`, `push`. A `pop` raised in the same cycle as an engine load is dropped, and so is a `push` raised with a `pop`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Empty the buffer and clear the flags |
| push | input | 1 | Host write strobe |
| push_data | input | DW | Host write byte |
| pop | input | 1 | Host read strobe |
| head_data | output | DW | Oldest byte, or all ones when empty |
| eng_load | input | 1 | Engine receive load strobe |
| eng_count | input | $clog2(DEPTH+1) | Number of bytes received (0..DEPTH) |
| eng_bytes | input | DEPTH*DW | Received bytes, entry 0 in the low bits |
| fill | output | $clog2(DEPTH+1) | Number of stored bytes |
| has_data | output | 1 | Data-present flag |
| full | output | 1 | Full flag |

## Verification
The bench uses the default parameters, DEPTH = 4 and DW = 8. With these values four pushes fill the buffer, so the dropped fifth push and every flag transition fit in a short vector walk. A load of four bytes raises `full` in one step. Loads of 2 and 0 entries made while a flag is still set show that a load does not clear flags. Directed cycles with simultaneous requests check each level of the priority order.

// File: rtl/byte_stage_buf.sv
module byte_stage_buf #(
  parameter int DEPTH = 4,
  parameter int DW    = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  logic                push,
  input  logic [DW-1:0]       push_data,
  input  logic                pop,
  output logic [DW-1:0]       head_data,
  input  logic                eng_load,
  input  logic [CW-1:0]       eng_count,
  input  logic [DEPTH*DW-1:0] eng_bytes,
  output logic [CW-1:0]       fill,
  output logic                has_data,
  output logic                full
);

  logic [DW-1:0] mem [DEPTH];
  logic          empty;

  assign empty     = (fill == '0);
  assign head_data = empty ? {DW{1'b1}} : mem[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      fill     <= '0;
      has_data <= 1'b0;
      full     <= 1'b0;
    end else if (flush) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      fill     <= '0;
      has_data <= 1'b0;
      full     <= 1'b0;
    end else if (eng_load) begin
      for (int i = 0; i < DEPTH; i++)
        if (CW'(i) < eng_count) mem[i] <= eng_bytes[i*DW +: DW];
      fill <= eng_count;
      if (eng_count != '0)         has_data <= 1'b1;
      if (eng_count == CW'(DEPTH)) full     <= 1'b1;
    end else if (pop) begin
      if (!empty) begin
        for (int i = 0; i < DEPTH - 1; i++) mem[i] <= mem[i+1];
        mem[DEPTH-1] <= '0;
        fill <= fill - CW'(1);
        if (fill == CW'(DEPTH)) full     <= 1'b0;
        if (fill == CW'(1))     has_data <= 1'b0;
      end
    end else if (push && fill != CW'(DEPTH)) begin
      for (int i = 0; i < DEPTH; i++)
        if (CW'(i) == fill) mem[i] <= push_data;
      fill <= fill + CW'(1);
      if (empty)                  has_data <= 1'b1;
      if (fill == CW'(DEPTH - 1)) full     <= 1'b1;
    end
  end

endmodule

// File: rtl/byte_stage_buf_chk.sv
module byte_stage_buf_chk #(
  parameter int DEPTH = 4,
  parameter int DW    = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flush,
  input logic          push,
  input logic          pop,
  input logic          eng_load,
  input logic [CW-1:0] eng_count,
  input logic [DW-1:0] head_data,
  input logic [CW-1:0] fill,
  input logic          has_data,
  input logic          full
);

  p_empty_head_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fill == '0 |-> head_data == {DW{1'b1}});

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    push && !pop && !flush && !eng_load && fill == CW'(DEPTH)
    |=> fill == CW'(DEPTH) && $stable(head_data) && full);

  p_pop_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pop && !flush && !eng_load && fill != '0 |=> fill == $past(fill) - CW'(1));

  p_flush_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> fill == '0 && !has_data && !full);

  p_load_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
    eng_load && !flush && eng_count <= CW'(DEPTH) |=> fill == $past(eng_count));

  p_full_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full) |-> fill == CW'(DEPTH));

  p_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(DEPTH));

endmodule

bind byte_stage_buf byte_stage_buf_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .push(push), .pop(pop),
  .eng_load(eng_load), .eng_count(eng_count), .head_data(head_data),
  .fill(fill), .has_data(has_data), .full(full));

// File: tb/tb_byte_stage_buf.sv
module tb_byte_stage_buf;
  localparam int DEPTH = 4;
  localparam int DW    = 8;
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic flush = 0, push = 0, pop = 0, eng_load = 0;
  logic [DW-1:0] push_data = '0;
  logic [CW-1:0] eng_count = '0;
  logic [DEPTH*DW-1:0] eng_bytes = '0;
  logic [DW-1:0] head_data;
  logic [CW-1:0] fill;
  logic has_data, full;
  int checks = 0, errors = 0;
  logic [DW-1:0] seen;

  always #2.5 clk = ~clk;

  byte_stage_buf #(.DEPTH(DEPTH), .DW(DW)) dut (.*);

  // op: 0 push, 1 pop, 2 flush | data | read value | head after | fill | has | full
  localparam int NV = 17;
  localparam logic [30:0] VEC [NV] = '{
    {2'd1, 8'h00, 8'hFF, 8'hFF, 3'd0, 1'b0, 1'b0},
    {2'd0, 8'h11, 8'h00, 8'h11, 3'd1, 1'b1, 1'b0},
    {2'd0, 8'h22, 8'h00, 8'h11, 3'd2, 1'b1, 1'b0},
    {2'd0, 8'h33, 8'h00, 8'h11, 3'd3, 1'b1, 1'b0},
    {2'd0, 8'h44, 8'h00, 8'h11, 3'd4, 1'b1, 1'b1},
    {2'd0, 8'h55, 8'h00, 8'h11, 3'd4, 1'b1, 1'b1},
    {2'd1, 8'h00, 8'h11, 8'h22, 3'd3, 1'b1, 1'b0},
    {2'd0, 8'h66, 8'h00, 8'h22, 3'd4, 1'b1, 1'b1},
    {2'd1, 8'h00, 8'h22, 8'h33, 3'd3, 1'b1, 1'b0},
    {2'd1, 8'h00, 8'h33, 8'h44, 3'd2, 1'b1, 1'b0},
    {2'd1, 8'h00, 8'h44, 8'h66, 3'd1, 1'b1, 1'b0},
    {2'd1, 8'h00, 8'h66, 8'hFF, 3'd0, 1'b0, 1'b0},
    {2'd1, 8'h00, 8'hFF, 8'hFF, 3'd0, 1'b0, 1'b0},
    {2'd0, 8'h77, 8'h00, 8'h77, 3'd1, 1'b1, 1'b0},
    {2'd2, 8'h00, 8'h00, 8'hFF, 3'd0, 1'b0, 1'b0},
    {2'd0, 8'h88, 8'h00, 8'h88, 3'd1, 1'b1, 1'b0},
    {2'd1, 8'h00, 8'h88, 8'hFF, 3'd0, 1'b0, 1'b0}
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic state(string tag, logic [DW-1:0] h, int n, bit hd, bit fu);
    chk({tag, " head"}, 32'(head_data), 32'(h));
    chk({tag, " fill"}, 32'(fill), n);
    chk({tag, " has_data"}, 32'(has_data), 32'(hd));
    chk({tag, " full"}, 32'(full), 32'(fu));
  endtask

  task automatic step(bit f, bit ps, bit pp, bit ld, int n, logic [DW-1:0] d,
                      logic [DEPTH*DW-1:0] b);
    @(negedge clk);
    flush = f; push = ps; pop = pp; eng_load = ld;
    eng_count = CW'(n); push_data = d; eng_bytes = b;
    #1 seen = head_data;
    @(posedge clk);
    #1 flush = 0; push = 0; pop = 0; eng_load = 0;
  endtask

  initial begin
    #100000;
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 state("R1 reset", 8'hFF, 0, 0, 0);
    rst_n = 1'b1;

    // R2 R3 R4 R5 R6 R7 R8 vector walk
    for (int k = 0; k < NV; k++) begin
      logic [30:0] v;
      v = VEC[k];
      step(v[30:29] == 2'd2, v[30:29] == 2'd0, v[30:29] == 2'd1, 0, 0, v[28:21], '0);
      if (v[30:29] == 2'd1) chk($sformatf("R4 R5 vec%0d read", k), 32'(seen), 32'(v[20:13]));
      state($sformatf("R2 R3 R6 R7 vec%0d", k), v[12:5], int'(v[4:2]), v[1], v[0]);
    end

    // R9 load of two bytes
    step(0, 0, 0, 1, 2, 0, 32'hA4A3A2A1);
    state("R9 load2", 8'hA1, 2, 1, 0);
    step(0, 0, 1, 0, 0, 0, '0);
    state("R9 load2 pop", 8'hA2, 1, 1, 0);
    // R9 full load
    step(0, 0, 0, 1, 4, 0, 32'hB4B3B2B1);
    state("R9 load4", 8'hB1, 4, 1, 1);
    // R9 load does not clear full
    step(0, 0, 0, 1, 2, 0, 32'hC4C3C2C1);
    state("R9 sticky full", 8'hC1, 2, 1, 1);
    // R7 pop below full leaves sticky full alone
    step(0, 0, 1, 0, 0, 0, '0);
    state("R7 pop keeps full", 8'hC2, 1, 1, 1);
    // R9 zero-count load keeps has_data
    step(0, 0, 0, 1, 0, 0, '0);
    state("R9 load0", 8'hFF, 0, 1, 1);
    step(1, 0, 0, 0, 0, 0, '0);
    state("R8 flush", 8'hFF, 0, 0, 0);

    // R10 priority
    step(0, 1, 0, 0, 0, 8'h5A, '0);
    step(0, 0, 1, 1, 3, 0, 32'hD4D3D2D1);
    state("R10 load beats pop", 8'hD1, 3, 1, 0);
    step(1, 1, 1, 1, 4, 8'h01, 32'hE4E3E2E1);
    state("R10 flush beats all", 8'hFF, 0, 0, 0);
    step(0, 1, 0, 0, 0, 8'h3C, '0);
    step(0, 1, 1, 0, 0, 8'h4D, '0);
    chk("R10 pop value", 32'(seen), 32'h3C);
    state("R10 pop beats push", 8'hFF, 0, 0, 0);
    step(0, 1, 1, 0, 0, 8'h6E, '0);
    state("R10 R5 empty pop drops push", 8'hFF, 0, 0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule